// File: doc/BRIEF.md
# Streaming Frame Boundary Checker

This block sits on a sample stream whose beats carry a start marker and an end marker, and checks the framing of every frame that passes. A beat is a cycle in which the source presents a sample (`in_valid`) and the sink accepts it (`in_ready`). A well-formed frame holds exactly `FRAME_LEN` beats. The start marker sits on its first beat and the end marker on its last.

Every accepted beat is forwarded one cycle later on the output stream, together with its markers. A 2-bit error code travels with the beat, so a consumer can see which sample broke the framing. A missing end marker, a missing start marker and a marker in the wrong place each have their own code. After a missing end marker the frame is closed. An end marker that arrives one beat late therefore shows as a missing end on the final sample, followed by a missing start on the late beat.

`FRAME_LEN` must be at least 2. The reset input is asynchronous and active low. It is expected to be released in step with `clk`.

Top module: `frame_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first beat, `out_valid` is 0 and `err_code` is 2'b00, and no frame is open.
- R2: Every beat appears on the output one cycle later, with `out_valid` high, `out_data` equal to the sample, and `out_first`/`out_last` equal to the markers. In a cycle after a non-beat, `out_valid` is 0.
- R3: A cycle with `in_valid` or `in_ready` low is not a beat. It does not advance the sample count, and it produces no output and no error, whatever the markers and data are.
- R4: A frame of exactly `FRAME_LEN` beats, with the start marker on beat 1 and the end marker only on beat `FRAME_LEN`, gives `err_code` 2'b00 on every one of its beats and then closes.
- R5: If beat `FRAME_LEN` of an open frame lacks the end marker, that beat is output with `err_code` 2'b10 and the frame is closed.
- R6: A beat without the start marker while no frame is open is output with `err_code` 2'b01, and the stream stays closed.
- R7: An end marker on an open frame before beat `FRAME_LEN` is output with `err_code` 2'b11, and the frame is closed.
- R8: A start marker without an end marker inside an open frame is output with `err_code` 2'b11. A new frame then opens with that beat counted as beat 1.
- R9: The error code is carried only by the output cycle of the offending beat. The next cycle shows 2'b00 unless that cycle carries another faulty beat.
- R10: A beat that carries both markers gives `err_code` 2'b11 and leaves the stream closed, whether or not a frame was open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source presents a sample |
| in_ready | input | 1 | Sink accepts the sample |
| in_first | input | 1 | Start marker of the incoming sample |
| in_last | input | 1 | End marker of the incoming sample |
| in_data | input | DATA_W | Incoming sample |
| out_valid | output | 1 | Registered copy of a beat is present |
| out_first | output | 1 | Start marker of the forwarded beat |
| out_last | output | 1 | End marker of the forwarded beat |
| out_data | output | DATA_W | Forwarded sample |
| err_code | output | 2 | 00 none, 01 missing start, 10 missing end, 11 misplaced marker |

## Verification
The bench builds the checker with `FRAME_LEN` of 8 and `DATA_W` of 16. With these values, both the final-beat boundary and the one-beat-late end marker are reached in a handful of cycles. This also leaves room to stall the stream in the middle of a frame, and to restart a frame at a different beat position. The counter comparison against `FRAME_LEN-1` is exercised in exactly the same way as at the default length of 8192.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    ERR_NONE     = 2'b00,
    ERR_NO_START = 2'b01,
    ERR_NO_END   = 2'b10,
    ERR_MARKER   = 2'b11
  } fg_err_e;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'b00,
    CNT_LOAD1 = 2'b01,
    CNT_INC   = 2'b10
  } fg_cnt_op_e;
endpackage

// File: rtl/fg_decide.sv
module fg_decide
  import fg_pkg::*;
(
  input  logic       beat,
  input  logic       first,
  input  logic       last,
  input  logic       open_q,
  input  logic       at_end,
  output logic       open_d,
  output fg_cnt_op_e cnt_op,
  output fg_err_e    err
);
  always_comb begin
    open_d = open_q;
    cnt_op = CNT_HOLD;
    err    = ERR_NONE;
    if (beat) begin
      if (!open_q) begin
        if (!first) begin
          err = ERR_NO_START;
        end else if (last) begin
          err = ERR_MARKER;
        end else begin
          open_d = 1'b1;
          cnt_op = CNT_LOAD1;
        end
      end else if (first) begin
        err = ERR_MARKER;
        if (last) begin
          open_d = 1'b0;
        end else begin
          cnt_op = CNT_LOAD1;
        end
      end else if (at_end) begin
        open_d = 1'b0;
        if (!last) begin
          err = ERR_NO_END;
        end
      end else if (last) begin
        open_d = 1'b0;
        err    = ERR_MARKER;
      end else begin
        cnt_op = CNT_INC;
      end
    end
  end
endmodule

// File: rtl/fg_counter.sv
module fg_counter
  import fg_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fg_cnt_op_e       op,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (op != CNT_HOLD);
    cnt_d  = cnt_q;
    unique case (op)
      CNT_LOAD1: cnt_d = CNT_W'(1);
      CNT_INC:   cnt_d = cnt_q + CNT_W'(1);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fg_stage.sv
module fg_stage
  import fg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic              last,
  input  logic [DATA_W-1:0] data,
  input  fg_err_e           err,
  output logic              out_valid,
  output logic              out_first,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        err_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err_code  <= 2'b00;
    end else begin
      out_valid <= beat;
      err_code  <= err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (beat) begin
      out_first <= first;
      out_last  <= last;
      out_data  <= data;
    end
  end
endmodule

// File: rtl/frame_guard.sv
module frame_guard
  import fg_pkg::*;
#(
  parameter int FRAME_LEN = 8192,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ready,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_first,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        err_code
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] END_IDX = CNT_W'(FRAME_LEN - 1);

  logic             beat;
  logic             open_q;
  logic             open_d;
  logic             at_end;
  logic [CNT_W-1:0] cnt_q;
  fg_cnt_op_e       cnt_op;
  fg_err_e          err;

  assign beat   = in_valid & in_ready;
  assign at_end = (cnt_q == END_IDX);

  fg_decide u_decide (
    .beat   (beat),
    .first  (in_first),
    .last   (in_last),
    .open_q (open_q),
    .at_end (at_end),
    .open_d (open_d),
    .cnt_op (cnt_op),
    .err    (err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (beat) begin
      open_q <= open_d;
    end
  end

  fg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (cnt_op),
    .cnt_q (cnt_q)
  );

  fg_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .first     (in_first),
    .last      (in_last),
    .data      (in_data),
    .err       (err),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_last  (out_last),
    .out_data  (out_data),
    .err_code  (err_code)
  );
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int FRAME_LEN = 8192,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_first,
  input logic              in_last,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        err_code,
  input logic              open_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LEN_C    = CNT_W'(FRAME_LEN);

  logic beat;
  assign beat = in_valid & in_ready;

  a_r2_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (out_valid && out_data == $past(in_data)));

  a_r3_no_beat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> (!out_valid && err_code == 2'b00));

  a_r4_clean_close: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && open_q && !in_first && in_last && cnt_q == LAST_IDX)
      |=> (err_code == 2'b00 && !open_q));

  a_r5_missing_end: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && open_q && !in_first && !in_last && cnt_q == LAST_IDX)
      |=> (err_code == 2'b10 && !open_q));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (cnt_q < LEN_C));

  a_r6_missing_start: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !open_q && !in_first) |=> (err_code == 2'b01 && !open_q));

  a_r7_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && open_q && !in_first && in_last && cnt_q != LAST_IDX)
      |=> (err_code == 2'b11 && !open_q));

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && open_q && in_first && !in_last)
      |=> (err_code == 2'b11 && open_q && cnt_q == CNT_W'(1)));

  a_r10_both_markers: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_first && in_last) |=> (err_code == 2'b11 && !open_q));
endmodule

bind frame_guard fg_checker #(
  .FRAME_LEN (FRAME_LEN),
  .DATA_W    (DATA_W),
  .CNT_W     (CNT_W)
) u_fg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_first  (in_first),
  .in_last   (in_last),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .err_code  (err_code),
  .open_q    (open_q),
  .cnt_q     (cnt_q)
);

// File: tb/frame_guard_test.sv
module frame_guard_test;
  localparam int LEN = 8;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready = 1'b0;
  logic          in_first = 1'b0;
  logic          in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_first;
  logic          out_last;
  logic [DW-1:0] out_data;
  logic [1:0]    err_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_guard #(.FRAME_LEN(LEN), .DATA_W(DW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_first  (in_first),
    .in_last   (in_last),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_last  (out_last),
    .out_data  (out_data),
    .err_code  (err_code)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic r, input logic f,
                      input logic l, input logic [DW-1:0] d,
                      input logic exp_v, input logic [1:0] exp_e,
                      input string req);
    @(negedge clk);
    in_valid = v; in_ready = r; in_first = f; in_last = l; in_data = d;
    @(posedge clk);
    #1;
    check(32'(out_valid), 32'(exp_v), req, "out_valid");
    check(32'(err_code), 32'(exp_e), req, "err_code");
    if (exp_v) begin
      check(32'(out_data), 32'(d), "R2", "out_data");
      check(32'(out_first), 32'(f), "R2", "out_first");
      check(32'(out_last), 32'(l), "R2", "out_last");
    end
  endtask

  task automatic beat(input logic f, input logic l, input logic [DW-1:0] d,
                      input logic [1:0] exp_e, input string req);
    step(1'b1, 1'b1, f, l, d, 1'b1, exp_e, req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 2'b00, req);
  endtask

  task automatic t_reset;
    check(32'(out_valid), 32'd0, "R1", "out_valid in reset");
    check(32'(err_code), 32'd0, "R1", "err_code in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
  endtask

  task automatic t_good_frame(input logic [DW-1:0] base);
    for (int i = 0; i < LEN; i++) begin
      beat(i == 0, i == LEN - 1, base + DW'(i), 2'b00, "R4");
    end
    idle("R9");
  endtask

  task automatic t_stall;
    for (int i = 0; i < 3; i++) beat(i == 0, 1'b0, 16'h100 + DW'(i), 2'b00, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b1, 16'hdead, 1'b0, 2'b00, "R3");
    step(1'b0, 1'b1, 1'b1, 1'b1, 16'hbeef, 1'b0, 2'b00, "R3");
    for (int i = 3; i < LEN; i++) beat(1'b0, i == LEN - 1, 16'h100 + DW'(i), 2'b00, "R3");
    idle("R9");
  endtask

  task automatic t_late_end;
    for (int i = 0; i < LEN - 1; i++) beat(i == 0, 1'b0, 16'h200 + DW'(i), 2'b00, "R4");
    beat(1'b0, 1'b0, 16'h2ff, 2'b10, "R5");
    beat(1'b0, 1'b1, 16'h300, 2'b01, "R6");
    idle("R9");
  endtask

  task automatic t_missing_start;
    beat(1'b0, 1'b0, 16'h400, 2'b01, "R6");
    beat(1'b0, 1'b0, 16'h401, 2'b01, "R6");
    idle("R9");
    t_good_frame(16'h410);
  endtask

  task automatic t_early_end;
    beat(1'b1, 1'b0, 16'h500, 2'b00, "R7");
    beat(1'b0, 1'b0, 16'h501, 2'b00, "R7");
    beat(1'b0, 1'b1, 16'h502, 2'b11, "R7");
    beat(1'b0, 1'b0, 16'h503, 2'b01, "R7");
    idle("R9");
  endtask

  task automatic t_restart;
    for (int i = 0; i < 4; i++) beat(i == 0, 1'b0, 16'h600 + DW'(i), 2'b00, "R8");
    beat(1'b1, 1'b0, 16'h610, 2'b11, "R8");
    for (int i = 1; i < LEN; i++) beat(1'b0, i == LEN - 1, 16'h610 + DW'(i), 2'b00, "R8");
    idle("R9");
  endtask

  task automatic t_both_markers;
    beat(1'b1, 1'b1, 16'h700, 2'b11, "R10");
    beat(1'b0, 1'b0, 16'h701, 2'b01, "R10");
    for (int i = 0; i < 3; i++) beat(i == 0, 1'b0, 16'h710 + DW'(i), 2'b00, "R10");
    beat(1'b1, 1'b1, 16'h720, 2'b11, "R10");
    beat(1'b0, 1'b0, 16'h721, 2'b01, "R10");
    idle("R9");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_good_frame(16'h0010);
    t_stall();
    t_late_end();
    t_missing_start();
    t_early_end();
    t_restart();
    t_both_markers();
    t_good_frame(16'h0800);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule